// File: doc/BRIEF.md
# Backup Battery Health Monitor

This block decides when a backup battery is put under a test load and whether a battery warning is raised. A slow 1 Hz tick and a faster 1 kHz tick come from the chip's timebase. A power-good level, a comparator result that flags a weak battery, and a pulse that reports a fresh battery complete the inputs. The block drives the enable of the test load. It also drives the warning pin as an open-drain output, given as an output enable and a data value that is always low.

Each time power returns, the block waits a recovery delay counted in 1 kHz ticks. It then runs a test, even if the warning is already raised. A test that passes clears the warning. While the warning is clear and power stays good, tests repeat after a fixed number of 1 Hz ticks. Once the warning is raised it stays raised, and periodic tests stop, until a power-up test passes or a battery replacement is reported. All delays are parameters, so a bench can use short periods.

Top module: `batt_guard`

## Requirements
- R1: After reset, `load_en`, `warn_oe` and `warn_lo` are all 0.
- R2: `warn_lo` is 0 on every cycle. The pin is only pulled low, and only when `warn_oe` is 1.
- R3: After `pwr_good` becomes 1, `load_en` goes to 1 on the cycle after the RECOVER_TICKS-th `tick_1k` pulse. This forced test runs whatever the warning state is.
- R4: A test ends on the TEST_SECS-th `tick_1s` pulse after it starts, and `load_en` is 0 from the next cycle.
- R5: If `batt_low` is 1 in any cycle of a test while power is good and no replacement is reported, `warn_oe` is 1 from the next cycle.
- R6: `batt_low` outside a test has no effect on `warn_oe`.
- R7: `warn_oe` stays at 1 until a replacement is reported or a test finishes with `batt_low` never seen. A passing test sets `warn_oe` to 0 on the cycle after it ends.
- R8: With the warning clear, the next test starts on the cycle after the PERIOD_SECS-th `tick_1s` pulse that follows the end of the previous test.
- R9: While the warning is set and power stays good, no periodic test starts.
- R10: When `pwr_good` is 0, `load_en` is 0 from the next cycle and any test in progress is dropped. `warn_oe` keeps its value unless a replacement is reported, and the recovery delay starts again from zero when power returns.
- R11: A `batt_swap` pulse sets `warn_oe` to 0 on the next cycle. If power is good, it also restarts the recovery delay from zero, and a test follows that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz, counts the recovery delay |
| tick_1s | input | 1 | One-cycle pulse at 1 Hz, counts test length and test period |
| pwr_good | input | 1 | Main supply in tolerance |
| batt_low | input | 1 | Comparator: battery below its trip level |
| batt_swap | input | 1 | One-cycle pulse reporting a new battery |
| load_en | output | 1 | Connects the test load to the battery |
| warn_oe | output | 1 | Warning pin driver enable; 1 pulls the pin low |
| warn_lo | output | 1 | Warning pin data, always 0 |

## Verification
The assertions check several rules at the ports on every cycle. The load is off one cycle after power fails. The warning holds its value whenever no test is running and no replacement is reported. A replacement pulse clears the warning. A low battery seen during a test raises the warning. A test only starts on a tick edge. Exact timing needs the bench's scenarios: the recovery length, the test length and the period. The bench also shows that periodic testing stops while the warning is latched, that a power-up test releases the warning, and that a replacement restarts the recovery count. It does this by comparing against a countdown model over directed runs and a long random sweep.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RECOVER = 2'd1,
    ST_TEST    = 2'd2,
    ST_IDLE    = 2'd3
  } bg_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/batt_guard_cnt.sv
module batt_guard_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] lim,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  function automatic logic is_last(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return c == (l - ONE);
  endfunction

  assign done = step && is_last(cnt, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr || done)   cnt <= '0;
    else if (step)          cnt <= cnt + ONE;
  end

  assert_cnt_below_lim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < lim);

endmodule

// File: rtl/batt_guard_fsm.sv
module batt_guard_fsm
  import batt_guard_pkg::*;
#(
  parameter int CW           = 8,
  parameter int RECOVER_TICKS = 125,
  parameter int PERIOD_SECS  = 86400,
  parameter int TEST_SECS    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          swap,
  input  logic          tick_1k,
  input  logic          tick_1s,
  input  logic          warn,
  input  logic          done,
  output bg_state_e     state,
  output logic          step,
  output logic [CW-1:0] lim,
  output logic          clr,
  output logic          test_start,
  output logic          test_end
);
  bg_state_e nxt;

  always_comb begin
    nxt        = state;
    test_start = 1'b0;
    test_end   = 1'b0;
    if (!pwr_good) begin
      nxt = ST_OFF;
    end else if (swap && state != ST_OFF) begin
      nxt = ST_RECOVER;
    end else begin
      case (state)
        ST_OFF:     nxt = ST_RECOVER;
        ST_RECOVER: if (done) begin nxt = ST_TEST; test_start = 1'b1; end
        ST_TEST:    if (done) begin nxt = ST_IDLE; test_end   = 1'b1; end
        ST_IDLE:    if (done) begin nxt = ST_TEST; test_start = 1'b1; end
        default:    nxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_RECOVER: begin step = tick_1k;           lim = CW'(RECOVER_TICKS); end
      ST_TEST:    begin step = tick_1s;           lim = CW'(TEST_SECS);     end
      ST_IDLE:    begin step = tick_1s && !warn;  lim = CW'(PERIOD_SECS);   end
      default:    begin step = 1'b0;              lim = CW'(RECOVER_TICKS); end
    endcase
  end

  assign clr = (nxt != state) || swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assert_start_from_timed_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_start |-> (state == ST_RECOVER || state == ST_IDLE));

endmodule

// File: rtl/batt_guard_warn.sv
module batt_guard_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic in_test,
  input  logic pwr_good,
  input  logic batt_low,
  input  logic swap,
  input  logic test_start,
  input  logic test_end,
  output logic warn
);
  logic fail_seen;
  logic low_hit;

  assign low_hit = in_test && pwr_good && batt_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fail_seen <= 1'b0;
    else if (test_start) fail_seen <= 1'b0;
    else if (low_hit)    fail_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      warn <= 1'b0;
    else if (swap)                   warn <= 1'b0;
    else if (low_hit)                warn <= 1'b1;
    else if (test_end && !fail_seen) warn <= 1'b0;
  end

  assert_fail_implies_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && fail_seen && !swap) |-> warn);

endmodule

// File: rtl/batt_guard.sv
module batt_guard
  import batt_guard_pkg::*;
#(
  parameter int RECOVER_TICKS = 125,
  parameter int PERIOD_SECS  = 86400,
  parameter int TEST_SECS    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1k,
  input  logic tick_1s,
  input  logic pwr_good,
  input  logic batt_low,
  input  logic batt_swap,
  output logic load_en,
  output logic warn_oe,
  output logic warn_lo
);
  localparam int MAXL = int'(max3(RECOVER_TICKS, PERIOD_SECS, TEST_SECS));
  localparam int CW   = (MAXL < 2) ? 1 : $clog2(MAXL + 1);

  bg_state_e     state;
  logic          step, clr, done, test_start, test_end, warn;
  logic [CW-1:0] lim;

  batt_guard_fsm #(
    .CW(CW), .RECOVER_TICKS(RECOVER_TICKS), .PERIOD_SECS(PERIOD_SECS), .TEST_SECS(TEST_SECS)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .swap(batt_swap),
    .tick_1k(tick_1k), .tick_1s(tick_1s), .warn(warn), .done(done),
    .state(state), .step(step), .lim(lim), .clr(clr),
    .test_start(test_start), .test_end(test_end)
  );

  batt_guard_cnt #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .lim(lim), .done(done)
  );

  batt_guard_warn warn_i (
    .clk(clk), .rst_n(rst_n), .in_test(state == ST_TEST), .pwr_good(pwr_good),
    .batt_low(batt_low), .swap(batt_swap), .test_start(test_start),
    .test_end(test_end), .warn(warn)
  );

  assign load_en = (state == ST_TEST);
  assign warn_oe = warn;
  assign warn_lo = 1'b0;

  assert_load_off_after_pwrfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !load_en);
  assert_warn_kept_on_pwrfail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !batt_swap) |=> $stable(warn_oe));
  assert_warn_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !batt_swap) |=> $stable(warn_oe));
  assert_low_ignored_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> !$rose(warn_oe));
  assert_low_sets_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && pwr_good && batt_low && !batt_swap) |=> warn_oe);
  assert_swap_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    batt_swap |=> !warn_oe);
  assert_test_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> $past(tick_1k || tick_1s));
  assert_never_drive_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warn_oe |-> !warn_lo);

endmodule

// File: tb/batt_guard_tb_top.sv
module batt_guard_tb_top;
  localparam int REC = 3;
  localparam int PER = 5;
  localparam int TST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1k = 0, tick_1s = 0, pwr_good = 0, batt_low = 0, batt_swap = 0;
  logic load_en, warn_oe, warn_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  batt_guard #(.RECOVER_TICKS(REC), .PERIOD_SECS(PER), .TEST_SECS(TST)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .tick_1s(tick_1s),
    .pwr_good(pwr_good), .batt_low(batt_low), .batt_swap(batt_swap),
    .load_en(load_en), .warn_oe(warn_oe), .warn_lo(warn_lo)
  );

  // Countdown model: phase 0 off, 1 recovering, 2 testing, 3 waiting
  int m_ph = 0, m_left = 0;
  bit m_warn = 0, m_bad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_warn = 0; m_bad = 0;
    end else begin
      bit w;
      w = m_warn;
      if (batt_swap) w = 0;
      case (m_ph)
        0: if (pwr_good) begin m_ph = 1; m_left = REC; end
        1: if (!pwr_good) m_ph = 0;
           else if (batt_swap) m_left = REC;
           else if (tick_1k) begin
             if (m_left == 1) begin m_ph = 2; m_left = TST; m_bad = 0; end
             else m_left--;
           end
        2: if (!pwr_good) m_ph = 0;
           else if (batt_swap) begin m_ph = 1; m_left = REC; end
           else begin
             if (batt_low) begin w = 1; end
             if (tick_1s) begin
               if (m_left == 1) begin
                 m_ph = 3; m_left = PER;
                 if (!m_bad && !batt_low) w = 0;
               end else m_left--;
             end
             if (batt_low) m_bad = 1;
           end
        default: if (!pwr_good) m_ph = 0;
           else if (batt_swap) begin m_ph = 1; m_left = REC; end
           else if (!m_warn && tick_1s) begin
             if (m_left == 1) begin m_ph = 2; m_left = TST; m_bad = 0; end
             else m_left--;
           end
      endcase
      m_warn = w;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(load_en == (m_ph == 2), cur_req, "load_en vs model", load_en, (m_ph == 2));
    chk(warn_oe == m_warn, cur_req, "warn_oe vs model", warn_oe, m_warn);
    chk(warn_lo == 1'b0, "R2", "warn_lo", warn_lo, 0);
  endtask

  // drive at negedge, advance one clock, compare at the following negedge
  task automatic cyc(input bit pg, input bit k, input bit s, input bit low, input bit sw);
    pwr_good = pg; tick_1k = k; tick_1s = s; batt_low = low; batt_swap = sw;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic lit(input string req, input bit exp_load, input bit exp_warn);
    chk(load_en == exp_load, req, "load_en", load_en, exp_load);
    chk(warn_oe == exp_warn, req, "warn_oe", warn_oe, exp_warn);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(load_en == 0 && warn_oe == 0 && warn_lo == 0, "R1", "reset outputs",
        {load_en, warn_oe, warn_lo}, 0);
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(0, 0, 0, 0, 0);
    lit("R1", 0, 0);

    // power-up recovery then forced test
    cur_req = "R3";
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    lit("R3", 0, 0);
    cyc(1, 1, 0, 0, 0);
    lit("R3", 1, 0);

    // test length
    cur_req = "R4";
    cyc(1, 0, 1, 0, 0);
    lit("R4", 1, 0);
    cyc(1, 0, 1, 0, 0);
    lit("R4", 0, 0);

    // low outside a test ignored
    cur_req = "R6";
    cyc(1, 0, 0, 1, 0);
    lit("R6", 0, 0);
    cyc(1, 1, 0, 1, 0);
    lit("R6", 0, 0);

    // periodic test
    cur_req = "R8";
    for (int i = 0; i < PER - 1; i++) cyc(1, 0, 1, 0, 0);
    lit("R8", 0, 0);
    cyc(1, 0, 1, 0, 0);
    lit("R8", 1, 0);

    // low during test
    cur_req = "R5";
    cyc(1, 0, 0, 1, 0);
    lit("R5", 1, 1);
    cur_req = "R7";
    cyc(1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 0);
    lit("R7", 0, 1);

    // latched warning stops the schedule
    cur_req = "R9";
    for (int i = 0; i < 3 * PER; i++) begin
      cyc(1, 0, 1, 0, 0);
      lit("R9", 0, 1);
    end

    // power failure keeps the warning; power-up test runs and passes
    cur_req = "R10";
    cyc(0, 0, 0, 0, 0);
    lit("R10", 0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 0);
    lit("R10", 0, 1);
    cur_req = "R3";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < REC; i++) cyc(1, 1, 0, 0, 0);
    lit("R3", 1, 1);
    cur_req = "R7";
    cyc(1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 0);
    lit("R7", 0, 0);

    // power failure mid-test
    cur_req = "R10";
    for (int i = 0; i < PER; i++) cyc(1, 0, 1, 0, 0);
    lit("R10", 1, 0);
    cyc(1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    lit("R10", 0, 1);

    // replacement clears and restarts the recovery count
    cur_req = "R11";
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 1);
    lit("R11", 0, 0);
    for (int i = 0; i < REC - 1; i++) cyc(1, 1, 0, 0, 0);
    lit("R11", 0, 0);
    cyc(1, 1, 0, 0, 0);
    lit("R11", 1, 0);

    // long random sweep against the model
    cur_req = "R8";
    for (int i = 0; i < 6000; i++) begin
      bit pg, k, s, low, sw;
      pg  = ($urandom_range(0, 39) != 0);
      k   = ($urandom_range(0, 2) == 0);
      s   = ($urandom_range(0, 2) == 0);
      low = ($urandom_range(0, 9) == 0);
      sw  = ($urandom_range(0, 79) == 0);
      cyc(pg, k, s, low, sw);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule